// File: doc/BRIEF.md
# Prefixed Instruction Byte Decoder

This block is the byte-serial front end of an 8-bit processor whose instruction set grows through prefix bytes. Opcode bytes arrive one per valid/ready handshake. Two index prefixes choose an alternate index register. A bit-operation prefix and an extended prefix each switch to another opcode table. A signed displacement byte is collected whenever an indexed memory operand needs one. After the last byte of an instruction, the block emits a single decoded record.

The record carries:
- the table the opcode belongs to;
- the final opcode byte and its x/y/z/p/q fields;
- the index selection and the displacement;
- halt and no-operation flags;
- a base and a not-taken cycle count for the instruction classes whose timing is decided at decode.

The record is held until the consumer accepts it. While a record is held, no new byte is taken.

Top module: `pfx_decoder`

## Requirements
- R1: After synchronous reset, `dec_valid` is 0, `in_ready` is 1 and no index selection is pending.
- R2: Byte 0xDD selects index code 1 (IX) and byte 0xFD selects index code 2 (IY). Any run of these bytes may precede an instruction, and the last one in the run decides `dec_index`.
- R3: With an index pending, 0xCB makes the next byte the displacement and the byte after it the opcode. The record then reports table code 2 (indexed bit-operation).
- R4: With no index pending, 0xCB makes the next byte the opcode. The record reports table code 1, index 0 and displacement 0.
- R5: 0xED clears any pending index. The next byte is the opcode, with table code 3 and index 0.
- R6: An unprefixed opcode (table code 0) takes a trailing displacement byte only when an index is pending and the opcode is one of 0x34-0x36, 0x46, 0x4E, 0x56, 0x5E, 0x66, 0x6E, 0x70-0x75, 0x77, 0x7E, 0x86, 0x8E, 0x96, 0x9E, 0xA6, 0xAE, 0xB6 or 0xBE. In every other case the record appears on the cycle after the opcode is accepted, with displacement 0.
- R7: The fields are x = opcode[7:6], y = opcode[5:3], z = opcode[2:0], p = opcode[5:4] and q = opcode[3].
- R8: `dec_halt` is 1 only for unprefixed opcode 0x76.
- R9: In table 2, both cycle counts are 20 when opcode[7:6] is 01 and 23 otherwise.
- R10: Unprefixed conditional flow reports base/not-taken cycle pairs:
  - 0x10: 13/8;
  - 0x18: 12/12;
  - 0x20, 0x28, 0x30, 0x38: 12/8;
  - x=3 with z=0: 11/5;
  - x=3 with z=2: 10/7;
  - x=3 with z=4: 17/10.
  All other table 0 and table 1 opcodes report 0/0.
- R11: Extended opcodes 0xB0-0xB3 and 0xB8-0xBB report 21/16. Opcodes 0xA0-0xA3 and 0xA8-0xAB report 16/16. `dec_nop` is 1 for extended opcodes whose x is 0 or 3.
- R12: A record stays unchanged with `dec_valid` high until `dec_ready` is seen. During that time `in_ready` is 0. Each record clears the index for the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetch byte valid |
| in_byte | input | 8 | Fetched byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| dec_valid | output | 1 | Decoded record valid |
| dec_ready | input | 1 | Consumer accepts record |
| dec_table | output | 2 | 0 unprefixed, 1 bit-op, 2 indexed bit-op, 3 extended |
| dec_opcode | output | 8 | Final opcode byte |
| dec_x | output | 2 | Opcode bits 7:6 |
| dec_y | output | 3 | Opcode bits 5:3 |
| dec_z | output | 3 | Opcode bits 2:0 |
| dec_p | output | 2 | Opcode bits 5:4 |
| dec_q | output | 1 | Opcode bit 3 |
| dec_index | output | 2 | 0 none, 1 IX, 2 IY |
| dec_disp | output | 8 | Signed displacement, 0 if none fetched |
| dec_cyc_base | output | 5 | Base (taken or repeating) cycle count |
| dec_cyc_cond | output | 5 | Not-taken or terminating cycle count |
| dec_halt | output | 1 | Halt opcode |
| dec_nop | output | 1 | Extended no-operation opcode |

## Verification
The main function is exercised with:
- plain opcodes;
- mixed runs of index prefixes, where the last prefix must decide the index;
- indexed opcodes that are inside and outside the displacement set, which separates the trailing-displacement path from the immediate path;
- bit-operation prefixes with and without a pending index, which shows the displacement placed before the opcode only in the indexed form;
- an extended prefix following an index prefix, which shows the cancellation.

Cycle pairs are probed at each conditional class, at the repeating and terminating block forms, and on both sides of the bit-test split. A held record with the consumer stalled shows that input stops and the record stays stable.

// File: rtl/pfx_decoder_pkg.sv
package pfx_decoder_pkg;
    localparam int BYTE_W = 8;
    localparam int CYC_W  = 5;

    localparam logic [BYTE_W-1:0] PFX_IX   = 8'hDD;
    localparam logic [BYTE_W-1:0] PFX_IY   = 8'hFD;
    localparam logic [BYTE_W-1:0] PFX_BIT  = 8'hCB;
    localparam logic [BYTE_W-1:0] PFX_EXT  = 8'hED;
    localparam logic [BYTE_W-1:0] OP_HALT  = 8'h76;

    typedef enum logic [1:0] {
        TBL_BASE = 2'd0,
        TBL_BIT  = 2'd1,
        TBL_XBIT = 2'd2,
        TBL_EXT  = 2'd3
    } tbl_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_X    = 2'd1,
        IDX_Y    = 2'd2
    } idx_e;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_BITOP,
        ST_XDISP,
        ST_XBITOP,
        ST_EXTOP,
        ST_TAILDISP
    } st_e;

    typedef struct packed {
        logic [1:0] x;
        logic [2:0] y;
        logic [2:0] z;
        logic [1:0] p;
        logic       q;
    } fld_t;

    typedef struct packed {
        tbl_e              tbl;
        logic [BYTE_W-1:0] op;
        fld_t              f;
        idx_e              idx;
        logic [BYTE_W-1:0] disp;
        logic [CYC_W-1:0]  cyc_base;
        logic [CYC_W-1:0]  cyc_cond;
        logic              halt;
        logic              nop;
    } rec_t;
endpackage

// File: rtl/pfx_fields.sv
module pfx_fields
    import pfx_decoder_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output fld_t              fld_o
);
    always_comb begin
        fld_o.x = byte_i[7:6];
        fld_o.y = byte_i[5:3];
        fld_o.z = byte_i[2:0];
        fld_o.p = byte_i[5:4];
        fld_o.q = byte_i[3];
    end
endmodule

// File: rtl/pfx_disp_need.sv
module pfx_disp_need
    import pfx_decoder_pkg::*;
(
    input  fld_t fld_i,
    output logic need_o
);
    logic mem_incdec;
    logic load_from;
    logic store_to;
    logic alu_mem;

    always_comb begin
        // inc/dec/immediate store through (index+d): x=0, y=6, z=4..6
        mem_incdec = (fld_i.x == 2'd0) && (fld_i.y == 3'd6) &&
                     (fld_i.z >= 3'd4) && (fld_i.z <= 3'd6);
        // register loads from memory, excluding halt slot
        load_from  = (fld_i.x == 2'd1) && (fld_i.z == 3'd6) && (fld_i.y != 3'd6);
        // register stores to memory, excluding halt slot
        store_to   = (fld_i.x == 2'd1) && (fld_i.y == 3'd6) && (fld_i.z != 3'd6);
        // accumulator arithmetic with memory operand
        alu_mem    = (fld_i.x == 2'd2) && (fld_i.z == 3'd6);
        need_o     = mem_incdec | load_from | store_to | alu_mem;
    end
endmodule

// File: rtl/pfx_cycles.sv
module pfx_cycles
    import pfx_decoder_pkg::*;
(
    input  tbl_e             tbl_i,
    input  fld_t             fld_i,
    output logic [CYC_W-1:0] base_o,
    output logic [CYC_W-1:0] cond_o
);
    localparam logic [CYC_W-1:0] C_XBIT_TEST = CYC_W'(20);
    localparam logic [CYC_W-1:0] C_XBIT_RMW  = CYC_W'(23);
    localparam logic [CYC_W-1:0] C_DJNZ      = CYC_W'(13);
    localparam logic [CYC_W-1:0] C_JR        = CYC_W'(12);
    localparam logic [CYC_W-1:0] C_JR_NT     = CYC_W'(8);
    localparam logic [CYC_W-1:0] C_RET       = CYC_W'(11);
    localparam logic [CYC_W-1:0] C_RET_NT    = CYC_W'(5);
    localparam logic [CYC_W-1:0] C_JP        = CYC_W'(10);
    localparam logic [CYC_W-1:0] C_JP_NT     = CYC_W'(7);
    localparam logic [CYC_W-1:0] C_CALL      = CYC_W'(17);
    localparam logic [CYC_W-1:0] C_CALL_NT   = CYC_W'(10);
    localparam logic [CYC_W-1:0] C_BLK_REP   = CYC_W'(21);
    localparam logic [CYC_W-1:0] C_BLK_END   = CYC_W'(16);

    always_comb begin
        base_o = '0;
        cond_o = '0;
        unique case (tbl_i)
            TBL_XBIT: begin
                base_o = (fld_i.x == 2'd1) ? C_XBIT_TEST : C_XBIT_RMW;
                cond_o = base_o;
            end
            TBL_BASE: begin
                if (fld_i.x == 2'd0 && fld_i.z == 3'd0) begin
                    if (fld_i.y == 3'd2) begin
                        base_o = C_DJNZ;
                        cond_o = C_JR_NT;
                    end else if (fld_i.y == 3'd3) begin
                        base_o = C_JR;
                        cond_o = C_JR;
                    end else if (fld_i.y >= 3'd4) begin
                        base_o = C_JR;
                        cond_o = C_JR_NT;
                    end
                end else if (fld_i.x == 2'd3) begin
                    if (fld_i.z == 3'd0) begin
                        base_o = C_RET;
                        cond_o = C_RET_NT;
                    end else if (fld_i.z == 3'd2) begin
                        base_o = C_JP;
                        cond_o = C_JP_NT;
                    end else if (fld_i.z == 3'd4) begin
                        base_o = C_CALL;
                        cond_o = C_CALL_NT;
                    end
                end
            end
            TBL_EXT: begin
                if (fld_i.x == 2'd2 && fld_i.z <= 3'd3 && fld_i.y >= 3'd4) begin
                    base_o = (fld_i.y >= 3'd6) ? C_BLK_REP : C_BLK_END;
                    cond_o = C_BLK_END;
                end
            end
            default: begin
                base_o = '0;
                cond_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder
    import pfx_decoder_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [1:0]        dec_table,
    output logic [BYTE_W-1:0] dec_opcode,
    output logic [1:0]        dec_x,
    output logic [2:0]        dec_y,
    output logic [2:0]        dec_z,
    output logic [1:0]        dec_p,
    output logic              dec_q,
    output logic [1:0]        dec_index,
    output logic [BYTE_W-1:0] dec_disp,
    output logic [CYC_W-1:0]  dec_cyc_base,
    output logic [CYC_W-1:0]  dec_cyc_cond,
    output logic              dec_halt,
    output logic              dec_nop
);
    typedef struct packed {
        st_e               st;
        idx_e              idx;
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] disp;
        rec_t              rec;
        logic              rec_vld;
    } state_t;

    state_t d, q;

    logic [BYTE_W-1:0] cur_op;
    fld_t              cur_fld;
    logic              cur_need;
    tbl_e              cur_tbl;
    logic [CYC_W-1:0]  cur_base;
    logic [CYC_W-1:0]  cur_cond;
    logic [BYTE_W-1:0] cur_disp;

    // opcode under decode: stored one while waiting for trailing displacement
    assign cur_op = (q.st == ST_TAILDISP) ? q.op : in_byte;

    always_comb begin
        unique case (q.st)
            ST_BITOP:  cur_tbl = TBL_BIT;
            ST_XBITOP: cur_tbl = TBL_XBIT;
            ST_EXTOP:  cur_tbl = TBL_EXT;
            default:   cur_tbl = TBL_BASE;
        endcase
        unique case (q.st)
            ST_TAILDISP: cur_disp = in_byte;
            ST_XBITOP:   cur_disp = q.disp;
            default:     cur_disp = '0;
        endcase
    end

    pfx_fields    u_fld  (.byte_i(cur_op), .fld_o(cur_fld));
    pfx_disp_need u_need (.fld_i(cur_fld), .need_o(cur_need));
    pfx_cycles    u_cyc  (.tbl_i(cur_tbl), .fld_i(cur_fld),
                          .base_o(cur_base), .cond_o(cur_cond));

    logic take;
    logic emit;

    always_comb begin
        d    = q;
        emit = 1'b0;
        take = in_valid && !q.rec_vld;

        if (q.rec_vld && dec_ready) begin
            d.rec_vld = 1'b0;
        end

        if (take) begin
            unique case (q.st)
                ST_OPC: begin
                    if (in_byte == PFX_IX) begin
                        d.idx = IDX_X;
                    end else if (in_byte == PFX_IY) begin
                        d.idx = IDX_Y;
                    end else if (in_byte == PFX_BIT) begin
                        d.st = (q.idx != IDX_NONE) ? ST_XDISP : ST_BITOP;
                    end else if (in_byte == PFX_EXT) begin
                        d.idx = IDX_NONE;
                        d.st  = ST_EXTOP;
                    end else if (q.idx != IDX_NONE && cur_need) begin
                        d.op = in_byte;
                        d.st = ST_TAILDISP;
                    end else begin
                        emit = 1'b1;
                    end
                end
                ST_XDISP: begin
                    d.disp = in_byte;
                    d.st   = ST_XBITOP;
                end
                default: emit = 1'b1;
            endcase
        end

        if (emit) begin
            d.rec.tbl      = cur_tbl;
            d.rec.op       = cur_op;
            d.rec.f        = cur_fld;
            d.rec.idx      = q.idx;
            d.rec.disp     = cur_disp;
            d.rec.cyc_base = cur_base;
            d.rec.cyc_cond = cur_cond;
            d.rec.halt     = (cur_tbl == TBL_BASE) && (cur_op == OP_HALT);
            d.rec.nop      = (cur_tbl == TBL_EXT) &&
                             ((cur_fld.x == 2'd0) || (cur_fld.x == 2'd3));
            d.rec_vld      = 1'b1;
            d.st           = ST_OPC;
            d.idx          = IDX_NONE;
            d.disp         = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            q.st      <= ST_OPC;
            q.idx     <= IDX_NONE;
            q.rec.tbl <= TBL_BASE;
            q.rec.idx <= IDX_NONE;
        end else begin
            q <= d;
        end
    end

    assign in_ready     = !q.rec_vld;
    assign dec_valid    = q.rec_vld;
    assign dec_table    = q.rec.tbl;
    assign dec_opcode   = q.rec.op;
    assign dec_x        = q.rec.f.x;
    assign dec_y        = q.rec.f.y;
    assign dec_z        = q.rec.f.z;
    assign dec_p        = q.rec.f.p;
    assign dec_q        = q.rec.f.q;
    assign dec_index    = q.rec.idx;
    assign dec_disp     = q.rec.disp;
    assign dec_cyc_base = q.rec.cyc_base;
    assign dec_cyc_cond = q.rec.cyc_cond;
    assign dec_halt     = q.rec.halt;
    assign dec_nop      = q.rec.nop;
endmodule

// File: rtl/pfx_decoder_chk.sv
module pfx_decoder_chk
    import pfx_decoder_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              dec_valid,
    input logic              dec_ready,
    input logic [1:0]        dec_table,
    input logic [BYTE_W-1:0] dec_opcode,
    input logic [1:0]        dec_x,
    input logic [2:0]        dec_y,
    input logic [2:0]        dec_z,
    input logic [1:0]        dec_p,
    input logic              dec_q,
    input logic [1:0]        dec_index,
    input logic [BYTE_W-1:0] dec_disp,
    input logic [CYC_W-1:0]  dec_cyc_base,
    input logic [CYC_W-1:0]  dec_cyc_cond,
    input logic              dec_halt,
    input logic              dec_nop
);
    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !dec_ready |=> dec_valid && $stable(dec_opcode) &&
        $stable(dec_table) && $stable(dec_disp) && $stable(dec_index));

    assert_ext_noidx_R5: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_table == 2'd3 |-> dec_index == 2'd0);

    assert_bit_plain_R4: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_table == 2'd1 |-> dec_index == 2'd0 && dec_disp == '0);

    assert_disp_idx_R6: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_disp != '0 |-> dec_index != 2'd0);

    assert_fields_R7: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> {dec_x, dec_y, dec_z} == dec_opcode &&
        {dec_p, dec_q} == dec_opcode[5:3]);

    assert_halt_R8: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_halt |-> dec_opcode == 8'h76 && dec_table == 2'd0);

    assert_xbit_cyc_R9: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_table == 2'd2 |->
        (dec_cyc_base == CYC_W'(20) || dec_cyc_base == CYC_W'(23)));

    assert_cond_le_R10: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> dec_cyc_cond <= dec_cyc_base);

    assert_nop_R11: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_nop |-> dec_table == 2'd3);
endmodule

bind pfx_decoder pfx_decoder_chk u_chk (.*);

// File: tb/pfx_decoder_bench.sv
module pfx_decoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       dec_valid;
    logic       dec_ready = 1'b0;
    logic [1:0] dec_table;
    logic [7:0] dec_opcode;
    logic [1:0] dec_x;
    logic [2:0] dec_y;
    logic [2:0] dec_z;
    logic [1:0] dec_p;
    logic       dec_q;
    logic [1:0] dec_index;
    logic [7:0] dec_disp;
    logic [4:0] dec_cyc_base;
    logic [4:0] dec_cyc_cond;
    logic       dec_halt;
    logic       dec_nop;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // captured record
    int r_tbl, r_op, r_x, r_y, r_z, r_p, r_q, r_idx, r_disp, r_base, r_cond, r_halt, r_nop;

    always #10 clk = ~clk;

    pfx_decoder u_pfx_decoder (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic get_rec();
        int waited = 0;
        @(negedge clk);
        while (!dec_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        r_tbl = dec_table; r_op = dec_opcode; r_x = dec_x; r_y = dec_y; r_z = dec_z;
        r_p = dec_p; r_q = dec_q; r_idx = dec_index; r_disp = dec_disp;
        r_base = dec_cyc_base; r_cond = dec_cyc_cond; r_halt = dec_halt; r_nop = dec_nop;
        dec_ready = 1'b1;
        @(posedge clk);
        #1;
        dec_ready = 1'b0;
    endtask

    task automatic valid_now(input string tag);
        @(negedge clk);
        chk(tag, dec_valid, 1);
    endtask

    task automatic t_reset();
        chk("R1 dec_valid", dec_valid, 0);
        chk("R1 in_ready", in_ready, 1);
        send(8'h00); get_rec();
        chk("R1 index after reset", r_idx, 0);
    endtask

    task automatic t_plain();
        send(8'h78); valid_now("R6 plain immediate"); get_rec();
        chk("R7 table", r_tbl, 0); chk("R7 op", r_op, 8'h78);
        chk("R7 x", r_x, 1); chk("R7 y", r_y, 7); chk("R7 z", r_z, 0);
        chk("R7 p", r_p, 3); chk("R7 q", r_q, 1);
        chk("R8 not halt", r_halt, 0);
        send(8'h76); get_rec();
        chk("R8 halt", r_halt, 1);
        send(8'h46); valid_now("R6 no index no disp"); get_rec();
        chk("R6 disp zero", r_disp, 0);
    endtask

    task automatic t_chain();
        send(8'hDD); send(8'hFD); send(8'hDD); send(8'h7E); send(8'h05); get_rec();
        chk("R2 last IX", r_idx, 1); chk("R6 disp", r_disp, 5); chk("R6 op", r_op, 8'h7E);
        send(8'hFD); send(8'hDD); send(8'hFD); send(8'h34); send(8'hFB); get_rec();
        chk("R2 last IY", r_idx, 2); chk("R6 neg disp", r_disp, 8'hFB);
        send(8'hDD); send(8'h7D); valid_now("R6 indexed outside set"); get_rec();
        chk("R6 idx kept", r_idx, 1); chk("R6 disp none", r_disp, 0);
        send(8'h00); get_rec();
        chk("R12 index cleared", r_idx, 0);
        send(8'hDD); send(8'h76); get_rec();
        chk("R8 indexed halt", r_halt, 1);
    endtask

    task automatic t_bitops();
        send(8'hCB); send(8'h46); get_rec();
        chk("R4 table", r_tbl, 1); chk("R4 idx", r_idx, 0); chk("R4 disp", r_disp, 0);
        chk("R4 op", r_op, 8'h46); chk("R10 bit-op zero", r_base, 0);
        send(8'hDD); send(8'hCB); send(8'h10); send(8'h46); get_rec();
        chk("R3 table", r_tbl, 2); chk("R3 idx", r_idx, 1);
        chk("R3 disp", r_disp, 8'h10); chk("R3 op", r_op, 8'h46);
        chk("R9 test base", r_base, 20); chk("R9 test cond", r_cond, 20);
        send(8'hFD); send(8'hCB); send(8'hF0); send(8'hC6); get_rec();
        chk("R3 IY", r_idx, 2); chk("R3 disp neg", r_disp, 8'hF0);
        chk("R9 rmw base", r_base, 23); chk("R9 rmw cond", r_cond, 23);
    endtask

    task automatic t_ext();
        send(8'hDD); send(8'hED); send(8'hB0); get_rec();
        chk("R5 table", r_tbl, 3); chk("R5 idx cleared", r_idx, 0);
        chk("R11 repeat base", r_base, 21); chk("R11 repeat cond", r_cond, 16);
        send(8'hED); send(8'hBB); get_rec();
        chk("R11 repeat out base", r_base, 21);
        send(8'hED); send(8'hA1); get_rec();
        chk("R11 single base", r_base, 16); chk("R11 single cond", r_cond, 16);
        send(8'hED); send(8'h00); get_rec();
        chk("R11 nop x0", r_nop, 1);
        send(8'hED); send(8'hFF); get_rec();
        chk("R11 nop x3", r_nop, 1);
        send(8'hED); send(8'h44); get_rec();
        chk("R11 not nop", r_nop, 0); chk("R5 op", r_op, 8'h44);
    endtask

    task automatic t_cond();
        send(8'h20); get_rec(); chk("R10 jr cc base", r_base, 12); chk("R10 jr cc cond", r_cond, 8);
        send(8'h10); get_rec(); chk("R10 djnz base", r_base, 13); chk("R10 djnz cond", r_cond, 8);
        send(8'h18); get_rec(); chk("R10 jr base", r_base, 12); chk("R10 jr cond", r_cond, 12);
        send(8'hC0); get_rec(); chk("R10 ret cc base", r_base, 11); chk("R10 ret cc cond", r_cond, 5);
        send(8'hCA); get_rec(); chk("R10 jp cc base", r_base, 10); chk("R10 jp cc cond", r_cond, 7);
        send(8'hFC); get_rec(); chk("R10 call cc base", r_base, 17); chk("R10 call cc cond", r_cond, 10);
        send(8'h00); get_rec(); chk("R10 other base", r_base, 0); chk("R10 other cond", r_cond, 0);
    endtask

    task automatic t_hold();
        send(8'h41);
        repeat (3) @(negedge clk);
        chk("R12 still valid", dec_valid, 1);
        chk("R12 in_ready low", in_ready, 0);
        chk("R12 op held", dec_opcode, 8'h41);
        get_rec();
        chk("R12 accepted op", r_op, 8'h41);
        @(negedge clk);
        chk("R12 released", dec_valid, 0);
        chk("R12 ready again", in_ready, 1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_chain();
        t_bitops();
        t_ext();
        t_cond();
        t_hold();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog: got 0 expected 1 (run completion)");
            summary();
            $finish;
        end
    end
endmodule